// File: doc/BRIEF.md
# MII Receive Frame Aligner

This block sits on the MAC side of a 4-bit media-independent receive interface. It runs on the receive clock that the PHY supplies. That clock is 2.5 MHz at 10 Mb/s and 25 MHz at 100 Mb/s. On every edge the block samples the data nibble, the data-valid strobe and the receive-error strobe. It then searches for the start-of-frame delimiter, which is a 0x5 nibble followed by a 0xD nibble. It drops everything up to and including that delimiter. The nibbles that follow are packed into bytes, low nibble first, and sent out as a byte stream. The first byte carries a start marker. The last byte carries an end marker together with two status flags: a frame-error flag and an alignment (dribble) flag.

A speed input selects how the delimiter is hunted. At 100 Mb/s, data-valid already covers the preamble, so the controller skips nibbles until it finds the first adjacent 0x5, 0xD pair. At 10 Mb/s, data-valid rises on the delimiter itself. The frame must therefore open with one or more 0x5 nibbles and then 0xD; otherwise the whole burst is thrown away. The block holds exactly one completed byte, so that the end marker can be placed on the last byte once data-valid falls.

The controller has six states. IDLE waits between bursts. PREAMBLE skips nibbles at 100 Mb/s. SFD_HI has seen 0x5 and waits for 0xD. LO waits for the low nibble of a byte. HI waits for the high nibble. DISCARD holds a rejected 10 Mb/s burst. The transitions, all taken while data-valid is high, are:

- From IDLE: 0x5 leads to SFD_HI. Any other nibble leads to PREAMBLE at 100 Mb/s, or to DISCARD at 10 Mb/s.
- From PREAMBLE: 0x5 leads to SFD_HI. Anything else stays in PREAMBLE.
- From SFD_HI: 0xD leads to LO (the frame starts). 0x5 stays in SFD_HI. Any other nibble falls back to PREAMBLE at 100 Mb/s, or goes to DISCARD at 10 Mb/s.
- LO always moves to HI, and HI always moves to LO.
- DISCARD stays in DISCARD.

Data-valid low sends every state back to IDLE. When that happens from LO or HI, the frame closes.

Top module: `mii_rx_aligner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid, out_sof, out_eof, out_err and out_align_err are all 0.
- R2: With speed_100=1, all nibbles before the first adjacent pair 0x5 then 0xD within a data-valid burst are discarded. The nibble after the 0xD is the first payload nibble.
- R3: With speed_100=0, a burst is accepted only if it starts with one or more 0x5 nibbles immediately followed by 0xD. Any other burst produces no output.
- R4: Payload nibble 2k is bits [3:0] and nibble 2k+1 is bits [7:4] of payload byte k.
- R5: A byte that is not the last is presented for one cycle, in the cycle after the edge that samples the high nibble of the following byte. The last complete byte is presented with out_eof=1 in the cycle after the edge that first samples rx_dv low.
- R6: out_sof is 1 on the first byte of a frame and 0 on every other byte.
- R7: out_align_err is 1 on the end byte when the frame had an odd number of payload nibbles, and 0 otherwise.
- R8: out_err is 1 on the end byte when rx_er was high on any payload nibble. rx_er during the preamble, during the delimiter, or while rx_dv is low has no effect.
- R9: A burst that ends before the delimiter is complete, or that carries fewer than two payload nibbles, produces no output at all.
- R10: rxd and rx_er are ignored while rx_dv is low, and a one-cycle gap is enough to separate two frames.
- R11: out_sof, out_eof, out_err and out_align_err are 0 whenever out_valid is 0. out_err and out_align_err are 0 on all bytes except the end byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock from the PHY |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_100 | input | 1 | 1 selects 100 Mb/s delimiter hunting, 0 selects 10 Mb/s |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error strobe |
| rxd | input | 4 | Receive data nibble |
| out_valid | output | 1 | Byte present this cycle |
| out_data | output | 8 | Assembled payload byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_err | output | 1 | Receive error seen in the payload (end byte only) |
| out_align_err | output | 1 | Odd payload nibble count (end byte only) |

## Verification
The bench targets the following corner cases:

- Delimiter search across repeated 0x5 nibbles and false starts such as 0x5, 0xA, 0x5, 0xD. A hunter that resets badly would either lock one nibble late, so every byte comes out with its halves swapped, or miss the frame altogether.
- 10 Mb/s bursts whose first nibble is not 0x5. A design that kept hunting would wrongly accept these.
- Odd payload lengths, single-nibble payloads and delimiter-only bursts. Wrong handling here would emit a half byte, drop the alignment flag, or produce an end marker with no data.
- rx_er placed in the preamble, in the payload and in the gap. An accumulator with the wrong window would set out_err on clean frames or miss real errors.
- Back-to-back frames with a one-cycle gap carrying junk on rxd. This exposes a pending byte or sticky flag that leaks into the next frame.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_SFD_HI,
        ST_LO,
        ST_HI,
        ST_DISCARD
    } rx_state_e;

endpackage

// File: rtl/mii_rx_fsm.sv
module mii_rx_fsm
    import mii_rx_pkg::*;
#(
    parameter int                NIB_W      = 4,
    parameter logic [NIB_W-1:0]  SFD_FIRST  = 'h5,
    parameter logic [NIB_W-1:0]  SFD_SECOND = 'hD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             speed_100,
    input  logic             rx_dv,
    input  logic [NIB_W-1:0] rxd,
    output logic             frame_start,
    output logic             take_lo,
    output logic             take_hi,
    output logic             frame_end,
    output logic             odd_end
);

    rx_state_e state_q;
    rx_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!rx_dv) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (rxd == SFD_FIRST)  state_d = ST_SFD_HI;
                    else if (speed_100)    state_d = ST_PREAMBLE;
                    else                   state_d = ST_DISCARD;
                end
                ST_PREAMBLE: begin
                    if (rxd == SFD_FIRST)  state_d = ST_SFD_HI;
                end
                ST_SFD_HI: begin
                    if (rxd == SFD_SECOND)      state_d = ST_LO;
                    else if (rxd == SFD_FIRST)  state_d = ST_SFD_HI;
                    else if (speed_100)         state_d = ST_PREAMBLE;
                    else                        state_d = ST_DISCARD;
                end
                ST_LO:      state_d = ST_HI;
                ST_HI:      state_d = ST_LO;
                ST_DISCARD: state_d = ST_DISCARD;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // decoded control pulses
    always_comb begin
        frame_start = 1'b0;
        take_lo     = 1'b0;
        take_hi     = 1'b0;
        frame_end   = 1'b0;
        odd_end     = 1'b0;
        unique case (state_q)
            ST_SFD_HI: frame_start = rx_dv && (rxd == SFD_SECOND);
            ST_LO: begin
                take_lo   = rx_dv;
                frame_end = !rx_dv;
            end
            ST_HI: begin
                take_hi   = rx_dv;
                frame_end = !rx_dv;
                odd_end   = !rx_dv;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mii_rx_status.sv
module mii_rx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic payload_nib,
    input  logic rx_er,
    output logic frame_err
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_err <= 1'b0;
        end else if (frame_start) begin
            frame_err <= 1'b0;
        end else if (payload_nib && rx_er) begin
            frame_err <= 1'b1;
        end
    end

endmodule

// File: rtl/mii_rx_packer.sv
module mii_rx_packer #(
    parameter int NIB_W = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  rxd,
    input  logic              frame_start,
    input  logic              take_lo,
    input  logic              take_hi,
    input  logic              frame_end,
    input  logic              odd_end,
    input  logic              frame_err,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_err,
    output logic              out_align_err
);

    logic [NIB_W-1:0]  lo_q;
    logic [BYTE_W-1:0] pend_q;
    logic              pend_valid_q;
    logic              pend_sof_q;
    logic              first_q;

    // held byte and low-nibble capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q         <= '0;
            pend_q       <= '0;
            pend_valid_q <= 1'b0;
            pend_sof_q   <= 1'b0;
            first_q      <= 1'b0;
        end else begin
            if (frame_start) begin
                pend_valid_q <= 1'b0;
                first_q      <= 1'b1;
            end
            if (take_lo) begin
                lo_q <= rxd;
            end
            if (take_hi) begin
                pend_q       <= {rxd, lo_q};
                pend_valid_q <= 1'b1;
                pend_sof_q   <= first_q;
                first_q      <= 1'b0;
            end
            if (frame_end) begin
                pend_valid_q <= 1'b0;
            end
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_data      <= '0;
            out_sof       <= 1'b0;
            out_eof       <= 1'b0;
            out_err       <= 1'b0;
            out_align_err <= 1'b0;
        end else begin
            out_valid     <= 1'b0;
            out_sof       <= 1'b0;
            out_eof       <= 1'b0;
            out_err       <= 1'b0;
            out_align_err <= 1'b0;
            if (pend_valid_q && (take_hi || frame_end)) begin
                out_valid     <= 1'b1;
                out_data      <= pend_q;
                out_sof       <= pend_sof_q;
                out_eof       <= frame_end;
                out_err       <= frame_end && frame_err;
                out_align_err <= odd_end;
            end
        end
    end

endmodule

// File: rtl/mii_rx_aligner.sv
module mii_rx_aligner #(
    parameter int NIB_W = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              speed_100,
    input  logic              rx_dv,
    input  logic              rx_er,
    input  logic [NIB_W-1:0]  rxd,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_err,
    output logic              out_align_err
);

    logic frame_start;
    logic take_lo;
    logic take_hi;
    logic frame_end;
    logic odd_end;
    logic frame_err;

    mii_rx_fsm #(.NIB_W(NIB_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .speed_100   (speed_100),
        .rx_dv       (rx_dv),
        .rxd         (rxd),
        .frame_start (frame_start),
        .take_lo     (take_lo),
        .take_hi     (take_hi),
        .frame_end   (frame_end),
        .odd_end     (odd_end)
    );

    mii_rx_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .payload_nib (take_lo || take_hi),
        .rx_er       (rx_er),
        .frame_err   (frame_err)
    );

    mii_rx_packer #(.NIB_W(NIB_W)) u_packer (
        .clk           (clk),
        .rst_n         (rst_n),
        .rxd           (rxd),
        .frame_start   (frame_start),
        .take_lo       (take_lo),
        .take_hi       (take_hi),
        .frame_end     (frame_end),
        .odd_end       (odd_end),
        .frame_err     (frame_err),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .out_sof       (out_sof),
        .out_eof       (out_eof),
        .out_err       (out_err),
        .out_align_err (out_align_err)
    );

endmodule

// File: rtl/mii_rx_checker.sv
module mii_rx_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_dv,
    input logic out_valid,
    input logic out_sof,
    input logic out_eof,
    input logic out_err,
    input logic out_align_err
);

    a_r11_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_sof || out_eof || out_err || out_align_err));

    a_r7_align_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        out_align_err |-> out_eof);

    a_r8_err_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_eof);

    a_r5_mid_byte_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eof) |-> $past(rx_dv));

    a_r5_end_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> !$past(rx_dv));

    a_r9_nothing_at_burst_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |=> !out_valid);

endmodule

bind mii_rx_aligner mii_rx_checker u_mii_rx_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_dv         (rx_dv),
    .out_valid     (out_valid),
    .out_sof       (out_sof),
    .out_eof       (out_eof),
    .out_err       (out_err),
    .out_align_err (out_align_err)
);

// File: tb/test_mii_rx_aligner.sv
module test_mii_rx_aligner;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       speed_100;
    logic       rx_dv;
    logic       rx_er;
    logic [3:0] rxd;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_sof;
    logic       out_eof;
    logic       out_err;
    logic       out_align_err;

    mii_rx_aligner i_mii_rx_aligner (
        .clk           (clk),
        .rst_n         (rst_n),
        .speed_100     (speed_100),
        .rx_dv         (rx_dv),
        .rx_er         (rx_er),
        .rxd           (rxd),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .out_sof       (out_sof),
        .out_eof       (out_eof),
        .out_err       (out_err),
        .out_align_err (out_align_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int         stamp;
        logic [7:0] data;
        bit         sof;
        bit         eof;
        bit         err;
        bit         aln;
    } exp_t;

    exp_t       expq[$];
    logic [3:0] nq[$];
    bit         eq[$];
    int         cyc = 0;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         checking = 0;
    bit         finished = 0;
    string      tag = "R1";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [12:0] act, input logic [12:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // compare on every clock against the expected stream
    always @(negedge clk) begin
        if (checking) begin
            logic [12:0] act;
            act = {out_valid, out_sof, out_eof, out_err, out_align_err, out_data};
            if (expq.size() > 0 && expq[0].stamp == cyc) begin
                exp_t e;
                logic [12:0] ex;
                e = expq.pop_front();
                ex = {1'b1, e.sof, e.eof, e.err, e.aln, e.data};
                // R4 R5 R6 R7 R8 byte content and placement
                chk(act == ex, tag, "byte", act, ex);
            end else begin
                // R9 R10 R11 nothing outside an expected slot
                chk(out_valid == 1'b0 && act[11:8] == 4'b0, tag, "idle", act, 13'h0);
            end
        end
    end

    // frame-level reference: build expected bytes then drive the burst
    task automatic run_frame(input string t, input int gap, input logic [3:0] junk, input bit junk_er);
        int n = nq.size();
        int s = -1;
        int e0 = cyc + 1;
        tag = t;
        if (speed_100) begin
            for (int i = 0; i + 1 < n; i++) begin
                if (nq[i] == 4'h5 && nq[i+1] == 4'hD) begin
                    s = i;
                    break;
                end
            end
        end else begin
            int i = 0;
            while (i < n && nq[i] == 4'h5) i++;
            if (i >= 1 && i < n && nq[i] == 4'hD) s = i - 1;
        end
        if (s >= 0) begin
            int p = s + 2;
            int m = n - p;
            int b = m / 2;
            bit fe = 0;
            for (int k = p; k < n; k++) fe |= eq[k];
            for (int j = 0; j < b; j++) begin
                exp_t e;
                e.data  = {nq[p+2*j+1], nq[p+2*j]};
                e.sof   = (j == 0);
                e.eof   = (j == b - 1);
                e.err   = e.eof && fe;
                e.aln   = e.eof && (m % 2 == 1);
                e.stamp = e.eof ? e0 + n : e0 + p + 2*j + 3;
                expq.push_back(e);
            end
        end
        for (int i = 0; i < n; i++) begin
            rx_dv = 1'b1;
            rxd   = nq[i];
            rx_er = eq[i];
            @(negedge clk);
        end
        rx_dv = 1'b0;
        rxd   = junk;
        rx_er = junk_er;
        repeat (gap) @(negedge clk);
        rxd   = 4'h0;
        rx_er = 1'b0;
        nq.delete();
        eq.delete();
    endtask

    task automatic add(input logic [3:0] nib, input bit er);
        nq.push_back(nib);
        eq.push_back(er);
    endtask

    task automatic add_pre(input int cnt);
        for (int i = 0; i < cnt; i++) add(4'h5, 0);
        add(4'hD, 0);
    endtask

    task automatic add_bytes(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        add(b0[3:0], 0); add(b0[7:4], 0);
        add(b1[3:0], 0); add(b1[7:4], 0);
        add(b2[3:0], 0); add(b2[7:4], 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        report();
    end

    initial begin
        rst_n     = 1'b0;
        speed_100 = 1'b1;
        rx_dv     = 1'b0;
        rx_er     = 1'b0;
        rxd       = 4'h0;
        repeat (3) @(negedge clk);
        // R1 outputs quiet in reset
        chk({out_valid, out_sof, out_eof, out_err, out_align_err} == 5'b0, "R1", "reset",
            {8'h0, out_valid, out_sof, out_eof, out_err, out_align_err}, 13'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({out_valid, out_sof, out_eof, out_err, out_align_err} == 5'b0, "R1", "after reset",
            {8'h0, out_valid, out_sof, out_eof, out_err, out_align_err}, 13'h0);
        checking = 1;

        // R2 R4 R5 R6 long preamble at 100 Mb/s
        add_pre(15); add_bytes(8'h12, 8'h34, 8'hAB);
        run_frame("R2", 3, 4'h0, 0);

        // R2 false start 5 A then 5 D
        add(4'h5, 0); add(4'h5, 0); add(4'hA, 0); add(4'h5, 0); add(4'hD, 0);
        add_bytes(8'hC3, 8'h00, 8'hFF);
        run_frame("R2", 2, 4'h0, 0);

        // R2 delimiter at first nibble, 100 Mb/s
        add_pre(1); add_bytes(8'h5D, 8'hD5, 8'h77);
        run_frame("R4", 2, 4'h0, 0);

        // R3 10 Mb/s frame opening on the delimiter
        speed_100 = 1'b0;
        @(negedge clk);
        add_pre(1); add_bytes(8'hDE, 8'hAD, 8'hBE);
        run_frame("R3", 2, 4'h0, 0);

        // R3 10 Mb/s burst with a leading non-delimiter nibble is dropped
        add(4'h0, 0); add_pre(1); add_bytes(8'h11, 8'h22, 8'h33);
        run_frame("R3", 2, 4'h0, 0);

        // R3 10 Mb/s broken delimiter
        add(4'h5, 0); add(4'h7, 0); add(4'h5, 0); add(4'hD, 0); add_bytes(8'h44, 8'h55, 8'h66);
        run_frame("R3", 2, 4'h0, 0);

        // R7 odd payload at 10 Mb/s
        add_pre(2); add_bytes(8'h81, 8'h92, 8'hA3); add(4'h9, 0);
        run_frame("R7", 2, 4'h0, 0);

        speed_100 = 1'b1;
        @(negedge clk);

        // R8 error on a payload nibble
        add_pre(7); add(4'h1, 0); add(4'h2, 0); add(4'h3, 1); add(4'h4, 0);
        run_frame("R8", 2, 4'h0, 0);

        // R8 error only in preamble and gap: not reported
        add(4'h5, 1); add(4'h5, 1); add(4'h5, 0); add(4'hD, 1); add(4'h6, 0); add(4'h7, 0);
        run_frame("R8", 3, 4'hF, 1);

        // R9 burst ends inside the preamble
        add(4'h5, 0); add(4'h5, 0); add(4'h5, 0);
        run_frame("R9", 2, 4'h0, 0);

        // R9 delimiter followed by a single nibble
        add_pre(3); add(4'hB, 0);
        run_frame("R9", 2, 4'h0, 0);

        // R9 delimiter only
        add_pre(3);
        run_frame("R9", 2, 4'h0, 0);

        // R10 back-to-back frames, one-cycle gap with junk
        add_pre(2); add_bytes(8'h01, 8'h02, 8'h03);
        run_frame("R10", 1, 4'hE, 1);
        add_pre(2); add(4'h9, 0); add(4'h8, 0);
        run_frame("R10", 1, 4'h5, 1);
        add_pre(1); add(4'h4, 1); add(4'h2, 0); add(4'h1, 0);
        run_frame("R10", 4, 4'hD, 0);

        // R4 R6 R11 random frames in both modes
        for (int f = 0; f < 40; f++) begin
            int plen = $urandom_range(0, 8);
            int len  = $urandom_range(0, 14);
            speed_100 = $urandom_range(0, 1);
            @(negedge clk);
            if ($urandom_range(0, 4) == 0) add(4'($urandom_range(0, 15)), 0);
            add_pre(plen + 1);
            for (int k = 0; k < len; k++) add(4'($urandom_range(0, 15)), ($urandom_range(0, 9) == 0));
            run_frame("R11", $urandom_range(1, 3), 4'($urandom_range(0, 15)), $urandom_range(0, 1));
        end

        repeat (4) @(negedge clk);
        // R5 every expected byte was seen
        chk(expq.size() == 0, "R5", "leftover expected bytes", 13'(expq.size()), 13'h0);
        report();
    end

endmodule